// File: doc/BRIEF.md
# Packed Left-Rotate Unit

This unit rotates a 64-bit operand to the left by a variable amount. It has two modes. In packed mode the word is split into equal lanes, and each lane rotates by its own count. That count is taken from the matching lane of a second register operand, or from one 8-bit immediate that all lanes share. In scalar mode only the low field of the chosen width is rotated, and a byte write-enable vector tells the register file which bytes to update. The upper bytes of the destination keep their old contents.

A single 2-bit size code sets the lane width in packed mode and the operand width in scalar mode. The result and the write enables are registered, so they appear one cycle after the operation is accepted. A new operation can be accepted every cycle. With 32-bit lanes, one operation rotates both halves of the word independently, which replaces a sequence of several shift, rotate and OR operations.

Top module: `simd_rotl_unit`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle in which `in_valid` was high, and low otherwise. A new operation may be accepted every cycle.
- R2: With `simd_en`=1 and `use_imm`=0, each lane of `src_data` is rotated left by the count found in the low bits of the same lane of `src_cnt`.
- R3: `size_code` selects the width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64.
- R4: A count is reduced modulo the width by keeping only its low log2(width) bits, so a count of width or more wraps around.
- R5: With `use_imm`=1, `imm_cnt` modulo the width is the count used for every lane and for the scalar operand.
- R6: With `simd_en`=0, bits [width-1:0] of `result` hold the low field of `src_data` rotated left, and all bits above the width are zero.
- R7: In scalar register mode the count is taken from the low log2(width) bits of `src_cnt`.
- R8: `byte_we` is 8'hFF in packed mode. In scalar mode it is 8'h01, 8'h03, 8'h0F or 8'hFF for size codes 0, 1, 2 and 3.
- R9: While `in_valid` is low, `result` and `byte_we` keep their last values.
- R10: After reset, `out_valid`, `result` and `byte_we` are all zero.
- R11: With 32-bit lanes in packed mode, the two halves rotate independently in one operation, each by its own count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| src_data | input | 64 | Value to rotate |
| src_cnt | input | 64 | Per-lane rotate counts (register form) |
| imm_cnt | input | 8 | Immediate rotate count |
| use_imm | input | 1 | 1: take the count from `imm_cnt`; 0: take it from `src_cnt` |
| simd_en | input | 1 | 1: packed lanes; 0: scalar low field |
| size_code | input | 2 | Lane or operand width code |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Rotated value |
| byte_we | output | 8 | Destination byte write enables |

## Verification
Every result is due exactly one clock after the edge at which its operation is accepted. This holds for `out_valid`, `result` and `byte_we`. The bench drives each operation on a falling edge and lets one rising edge capture it. It compares all three outputs on the next falling edge against a bit-by-bit reference model, and keeps `in_valid` high between operations so that back-to-back throughput is exercised. The hold checks drop `in_valid`, wait several edges, and require the outputs to stay unchanged.

// File: rtl/rotl_pkg.sv
package rotl_pkg;
  localparam int DATA_W   = 64;
  localparam int BYTE_W   = 8;
  localparam int NBYTES   = DATA_W / BYTE_W;
  localparam int NSIZES   = 4;

  typedef enum logic [1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_32 = 2'b10,
    SZ_64 = 2'b11
  } size_e;

  // width in bits for a given size class index
  function automatic int width_of(input int k);
    return BYTE_W << k;
  endfunction
endpackage

// File: rtl/rotl_lane.sv
module rotl_lane #(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] amt,
  output logic [W-1:0]  dout
);
  // log2 stage barrel rotator
  logic [W-1:0] stage [CW+1];

  assign stage[0] = din;

  for (genvar s = 0; s < CW; s++) begin : g_stage
    localparam int SH = 1 << s;
    always_comb begin
      if (amt[s]) stage[s+1] = {stage[s][W-SH-1:0], stage[s][W-1:W-SH]};
      else        stage[s+1] = stage[s];
    end
  end

  assign dout = stage[CW];
endmodule

// File: rtl/rotl_width_slice.sv
module rotl_width_slice #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int CW    = $clog2(LANE_W),
  localparam int NL    = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] src_data,
  input  logic [DATA_W-1:0] src_cnt,
  input  logic [7:0]        imm_cnt,
  input  logic              use_imm,
  output logic [DATA_W-1:0] rot
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [CW-1:0] amt;

    always_comb begin
      if (use_imm) amt = imm_cnt[CW-1:0];
      else         amt = src_cnt[l*LANE_W +: CW];
    end

    rotl_lane #(.W(LANE_W)) u_lane (
      .din  (src_data[l*LANE_W +: LANE_W]),
      .amt  (amt),
      .dout (rot[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/rotl_wmask.sv
module rotl_wmask #(
  parameter int DATA_W  = 64,
  localparam int NBYTES = DATA_W / 8
) (
  input  logic              simd_en,
  input  logic [1:0]        size_code,
  output logic [NBYTES-1:0] byte_we,
  output logic [DATA_W-1:0] bit_mask
);
  logic [4:0] nbytes_on;

  always_comb begin
    nbytes_on = 5'd1 << size_code;
    for (int b = 0; b < NBYTES; b++) begin
      byte_we[b] = simd_en || (b < int'(nbytes_on));
      bit_mask[b*8 +: 8] = {8{byte_we[b]}};
    end
  end
endmodule

// File: rtl/simd_rotl_unit.sv
module simd_rotl_unit
  import rotl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [63:0]       src_data,
  input  logic [63:0]       src_cnt,
  input  logic [7:0]        imm_cnt,
  input  logic              use_imm,
  input  logic              simd_en,
  input  logic [1:0]        size_code,
  output logic              out_valid,
  output logic [63:0]       result,
  output logic [7:0]        byte_we
);
  logic [DATA_W-1:0] rot_all [NSIZES];
  logic [DATA_W-1:0] rot_sel;
  logic [DATA_W-1:0] bit_mask;
  logic [NBYTES-1:0] we_new;

  logic              valid_d, valid_q;
  logic [DATA_W-1:0] result_d, result_q;
  logic [NBYTES-1:0] we_d, we_q;

  // one rotator slice per width class
  for (genvar k = 0; k < NSIZES; k++) begin : g_width
    rotl_width_slice #(
      .DATA_W (DATA_W),
      .LANE_W (width_of(k))
    ) u_slice (
      .src_data (src_data),
      .src_cnt  (src_cnt),
      .imm_cnt  (imm_cnt),
      .use_imm  (use_imm),
      .rot      (rot_all[k])
    );
  end

  assign rot_sel = rot_all[size_code];

  rotl_wmask #(.DATA_W(DATA_W)) u_wmask (
    .simd_en   (simd_en),
    .size_code (size_code),
    .byte_we   (we_new),
    .bit_mask  (bit_mask)
  );

  // next state
  always_comb begin
    valid_d  = in_valid;
    result_d = result_q;
    we_d     = we_q;
    if (in_valid) begin
      result_d = rot_sel & bit_mask;
      we_d     = we_new;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      we_q     <= '0;
    end else begin
      valid_q  <= valid_d;
      result_q <= result_d;
      we_q     <= we_d;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
  assign byte_we   = we_q;

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  simd_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && simd_en) |=> (byte_we == 8'hFF));
  // R8
  we_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((byte_we + 8'd1) & byte_we) == 8'd0 && byte_we[0]));
  // R6
  scalar_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !simd_en && size_code == 2'b00) |=> (result[63:8] == '0));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(byte_we)));
endmodule

// File: tb/test_simd_rotl_unit.sv
module test_simd_rotl_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] src_data, src_cnt;
  logic [7:0]  imm_cnt;
  logic        use_imm, simd_en;
  logic [1:0]  size_code;
  logic        out_valid;
  logic [63:0] result;
  logic [7:0]  byte_we;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  simd_rotl_unit i_simd_rotl_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_data(src_data), .src_cnt(src_cnt), .imm_cnt(imm_cnt),
    .use_imm(use_imm), .simd_en(simd_en), .size_code(size_code),
    .out_valid(out_valid), .result(result), .byte_we(byte_we)
  );

  function automatic logic [63:0] ref_rot(input logic [63:0] d, input logic [63:0] c,
      input logic [7:0] imm, input logic ui, input logic simd, input logic [1:0] sz);
    int w = 8 << sz;
    int lanes = simd ? 64 / w : 1;
    logic [63:0] r = '0;
    for (int l = 0; l < lanes; l++) begin
      int cnt = ui ? (int'(imm) % w) : (int'(c[l*w +: 8]) % w);
      for (int i = 0; i < w; i++)
        r[l*w + i] = d[l*w + ((i - cnt + w) % w)];
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_we(input logic simd, input logic [1:0] sz);
    if (simd) return 8'hFF;
    return 8'((1 << (1 << sz)) - 1);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // present one op at a falling edge, check at the following falling edge
  task automatic do_op(input string tag, input logic [63:0] d, input logic [63:0] c,
      input logic [7:0] imm, input logic ui, input logic simd, input logic [1:0] sz);
    in_valid = 1'b1; src_data = d; src_cnt = c; imm_cnt = imm;
    use_imm = ui; simd_en = simd; size_code = sz;
    @(negedge clk);
    check({tag, " R1 valid"}, 64'(out_valid), 64'd1);
    check({tag, " result"}, result, ref_rot(d, c, imm, ui, simd, sz));
    check({tag, " R8 byte_we"}, 64'(byte_we), 64'(ref_we(simd, sz)));
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] hold_r;
    logic [7:0]  hold_w;
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; src_data = '0; src_cnt = '0;
    imm_cnt = '0; use_imm = 1'b0; simd_en = 1'b0; size_code = 2'b00;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 out_valid", 64'(out_valid), 64'd0);
    check("R10 result", result, 64'd0);
    check("R10 byte_we", 64'(byte_we), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3 per-lane byte counts
    do_op("R2 R3 bytes", 64'h0123_4567_89AB_CDEF, 64'h0706_0504_0302_0100, 8'd0, 0, 1, 2'd0);
    // R4 wrap: 8 -> 0, 9 -> 1, 15 -> 7
    do_op("R4 wrap8", 64'h8181_8181_8181_8181, 64'h0F09_0811_1018_FF08, 8'd0, 0, 1, 2'd0);
    // R11 two 32-bit halves, counts 1 and 4
    do_op("R11 halves", 64'h8000_0001_0000_0003, 64'h0000_0004_0000_0001, 8'd0, 0, 1, 2'd2);
    // R4 wrap on 32-bit lanes: 33 -> 1, 32 -> 0
    do_op("R4 wrap32", 64'hF000_000F_1234_5678, 64'h0000_0021_0000_0020, 8'd0, 0, 1, 2'd2);
    // R5 immediate shared count, 200 mod 16 = 8
    do_op("R5 imm16", 64'h1122_3344_5566_7788, 64'hFFFF_FFFF_FFFF_FFFF, 8'd200, 1, 1, 2'd1);
    // R6 scalar 8-bit, upper zero
    do_op("R6 scalar8", 64'hFFFF_FFFF_FFFF_FF81, 64'h0000_0000_0000_0003, 8'd0, 0, 0, 2'd0);
    // R7 scalar 16-bit count from low bits of src_cnt
    do_op("R7 scalar16", 64'hAAAA_BBBB_CCCC_8001, 64'hFFFF_FFFF_FFFF_FF14, 8'd0, 0, 0, 2'd1);
    // R6 scalar 32 with immediate
    do_op("R6 scalar32", 64'hDEAD_BEEF_8765_4321, 64'h0, 8'd36, 1, 0, 2'd2);
    // R3 full 64-bit rotate
    do_op("R3 full64", 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0041, 8'd0, 0, 1, 2'd3);
    do_op("R8 scalar64", 64'h0123_4567_89AB_CDEF, 64'h0, 8'd63, 1, 0, 2'd3);

    // random back-to-back ops
    for (int n = 0; n < 400; n++) begin
      do_op("R2 R5 R6 R7 rand", {$urandom, $urandom}, {$urandom, $urandom},
            8'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
    end

    // R9 hold while idle
    hold_r = result; hold_w = byte_we;
    in_valid = 1'b0;
    src_data = 64'hFFFF_0000_FFFF_0000; src_cnt = 64'h0303_0303_0303_0303;
    simd_en = 1'b0; size_code = 2'd0;
    @(negedge clk);
    check("R1 idle valid", 64'(out_valid), 64'd0);
    repeat (3) @(negedge clk);
    check("R9 hold result", result, hold_r);
    check("R9 hold byte_we", 64'(byte_we), 64'(hold_w));

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule